// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block sits beside a DDR SDRAM command bus and samples it on every rising clock edge. From the clock-enable level, the chip-select, row-strobe, column-strobe and write-enable pins, the two bank-select bits and address bit 10, it works out which command the controller issued and which bank it targets. It also notes whether the command covers all banks and whether it asks for automatic precharge.

Alongside the decode it keeps a model of the device state. For each of the four banks it records whether a row is open. It tracks self-refresh and power-down residency, the quiet window after a mode-register write, and the burst and row-precharge window after a write that closes its bank automatically. Any command that the modelled state forbids raises a one-cycle violation flag. The block only observes the bus and never drives it, so it can be placed in a verification environment or kept in silicon as a protocol monitor.

All outputs are registered. The results for a command sampled at a rising edge appear just after that edge and hold until the next one. The clock-enable level from the previous edge is kept inside the block, and after reset it counts as high.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With clock enable high at both the previous and the current edge, the command pins decode as follows. Chip select high gives DESEL (1). With chip select low, the row, column and write strobes give: LLL MRS (2), LLH AREF (3), LHL PRE (9), LHH ACT (6), HLL WR (8), HLH RD (7), HHL BST (10), HHH NOP (0). Codes appear on `cmd_o`.
- R2: For ACT, RD, WR and PRE, `bank_o` equals `ba_i` (0 to 3 select banks A to D). For every other command it is 0.
- R3: For PRE, `all_banks_o` equals `a10_i`. A precharge with A10 high closes every bank, whatever `ba_i` holds. With A10 low it closes only the selected bank.
- R4: For RD and WR, `auto_pre_o` equals `a10_i`; it is 0 for every other command. A read with auto-precharge marks its bank closed in the same update.
- R5: RD or WR to a bank without an open row, or ACT to a bank whose row is open, sets `viol_state_o`. ACT opens the bank, and `bank_open_o` bit n shows bank n.
- R6: MRS while any bank is open sets `viol_mode_o`.
- R7: Any command other than NOP or DESEL in the MRS_GAP (2) edges after an MRS sets `viol_gap_o`.
- R8: AREF or self-refresh entry while any bank is open sets `viol_refresh_o`.
- R9: The AREF pattern with clock enable falling decodes as SREF_IN (4) and sets `sref_o`. Clock enable rising while in self-refresh decodes as SREF_OUT (5) and clears it.
- R10: NOP or DESEL with clock enable falling decodes as PDN_IN (11) and sets `pdn_o`. `pdn_active_o` is set when a bank was open at entry. Clock enable rising outside self-refresh decodes as PDN_OUT (12) and clears both. Clock enable low at both edges decodes as NOP.
- R11: After WR with auto-precharge to an open bank, RD or WR in the next BURST_LEN/2 edges sets `viol_wrap_o`. The bank closes at the last of those edges.
- R12: During the TRP_CYC edges after that burst end, ACT to the same bank sets `viol_wrap_o`. ACT to another bank, or ACT to that bank later, does not.
- R13: During reset every output is 0 and the previous clock-enable level is taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, sampled on rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock enable level |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank select |
| a10_i | input | 1 | Address bit 10 (all-banks / auto-precharge) |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BA_W | Target bank |
| all_banks_o | output | 1 | Precharge covers all banks |
| auto_pre_o | output | 1 | Read/write with auto-precharge |
| viol_state_o | output | 1 | Bank open/closed state violation |
| viol_mode_o | output | 1 | Mode write with a bank open |
| viol_refresh_o | output | 1 | Refresh with a bank open |
| viol_gap_o | output | 1 | Command inside post-mode-write gap |
| viol_wrap_o | output | 1 | Write-auto-precharge burst/tRP violation |
| bank_open_o | output | 2**BA_W | Per-bank row-open flags |
| sref_o | output | 1 | In self-refresh |
| pdn_o | output | 1 | In power-down |
| pdn_active_o | output | 1 | Power-down entered with a bank open |

## Verification
The assertions take it for granted that inputs are stable around the rising edge and that reset is held for at least one edge. They also assume self-refresh and power-down are entered and left only through clock-enable transitions, so the two residency flags never have to be resolved against each other. The stimulus drives every pin half a period away from the sampling edge. It reaches self-refresh and power-down only through explicit falling and rising clock-enable steps, and it resets the block between scenarios so that each one starts from the all-banks-idle state.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_DESEL    = 4'd1,
        CMD_MRS      = 4'd2,
        CMD_AREF     = 4'd3,
        CMD_SREF_IN  = 4'd4,
        CMD_SREF_OUT = 4'd5,
        CMD_ACT      = 4'd6,
        CMD_RD       = 4'd7,
        CMD_WR       = 4'd8,
        CMD_PRE      = 4'd9,
        CMD_BST      = 4'd10,
        CMD_PDN_IN   = 4'd11,
        CMD_PDN_OUT  = 4'd12
    } cmd_e;

    function automatic logic cmd_is_idle(cmd_e c);
        return (c == CMD_NOP) || (c == CMD_DESEL);
    endfunction

    function automatic logic cmd_has_bank(cmd_e c);
        return (c == CMD_ACT) || (c == CMD_RD) || (c == CMD_WR) || (c == CMD_PRE);
    endfunction

    function automatic logic cmd_is_rw(cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_mon_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic            cke_prev_i,
    input  logic            cke_i,
    input  logic            in_sref_i,
    input  logic            cs_ni,
    input  logic            ras_ni,
    input  logic            cas_ni,
    input  logic            we_ni,
    input  logic [BA_W-1:0] ba_i,
    input  logic            a10_i,
    output cmd_e            cmd_o,
    output logic [BA_W-1:0] bank_o,
    output logic            all_banks_o,
    output logic            auto_pre_o
);

    cmd_e pin_cmd;

    // Pin pattern alone (clock enable not considered)
    always_comb begin
        if (cs_ni) begin
            pin_cmd = CMD_DESEL;
        end else begin
            unique case ({ras_ni, cas_ni, we_ni})
                3'b000:  pin_cmd = CMD_MRS;
                3'b001:  pin_cmd = CMD_AREF;
                3'b010:  pin_cmd = CMD_PRE;
                3'b011:  pin_cmd = CMD_ACT;
                3'b100:  pin_cmd = CMD_WR;
                3'b101:  pin_cmd = CMD_RD;
                3'b110:  pin_cmd = CMD_BST;
                default: pin_cmd = CMD_NOP;
            endcase
        end
    end

    // Clock-enable transitions override the pin pattern
    always_comb begin
        if (!cke_prev_i) begin
            if (cke_i) begin
                cmd_o = in_sref_i ? CMD_SREF_OUT : CMD_PDN_OUT;
            end else begin
                cmd_o = CMD_NOP;
            end
        end else if (!cke_i && (pin_cmd == CMD_AREF)) begin
            cmd_o = CMD_SREF_IN;
        end else if (!cke_i && cmd_is_idle(pin_cmd)) begin
            cmd_o = CMD_PDN_IN;
        end else begin
            cmd_o = pin_cmd;
        end
        bank_o      = cmd_has_bank(cmd_o) ? ba_i : '0;
        all_banks_o = (cmd_o == CMD_PRE) && a10_i;
        auto_pre_o  = cmd_is_rw(cmd_o) && a10_i;
    end

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
    import ddr_mon_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int BURST_LEN = 4,
    parameter int TRP_CYC   = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  cmd_e                 cmd_i,
    input  logic [BA_W-1:0]      bank_i,
    input  logic                 all_banks_i,
    input  logic                 auto_pre_i,
    output logic [(1<<BA_W)-1:0] open_o,
    output logic                 viol_state_o,
    output logic                 viol_wrap_o
);

    localparam int NB   = 1 << BA_W;
    localparam int HALF = BURST_LEN / 2;
    localparam int CW   = $clog2(HALF + 1);
    localparam int TW   = $clog2(TRP_CYC + 1);

    typedef struct packed {
        logic [NB-1:0]   open;
        logic [CW-1:0]   burst_cnt;
        logic [TW-1:0]   trp_cnt;
        logic [BA_W-1:0] wbank;
    } trk_t;

    trk_t st_d, st_q;
    logic burst_on;
    logic is_rw;

    always_comb begin
        st_d     = st_q;
        burst_on = (st_q.burst_cnt != '0);
        is_rw    = cmd_is_rw(cmd_i);

        viol_state_o = (is_rw && !st_q.open[bank_i]) ||
                       ((cmd_i == CMD_ACT) && st_q.open[bank_i]);
        viol_wrap_o  = (burst_on && is_rw) ||
                       ((st_q.trp_cnt != '0) && (cmd_i == CMD_ACT) &&
                        (bank_i == st_q.wbank));

        // Burst and precharge timers
        if (burst_on) begin
            st_d.burst_cnt = st_q.burst_cnt - 1'b1;
            if (st_q.burst_cnt == CW'(1)) begin
                st_d.open[st_q.wbank] = 1'b0;
                st_d.trp_cnt          = TW'(TRP_CYC);
            end
        end else if (st_q.trp_cnt != '0) begin
            st_d.trp_cnt = st_q.trp_cnt - 1'b1;
        end

        // Command effects on the bank model
        unique case (cmd_i)
            CMD_ACT: st_d.open[bank_i] = 1'b1;
            CMD_PRE: begin
                if (all_banks_i) begin
                    st_d.open = '0;
                end else begin
                    st_d.open[bank_i] = 1'b0;
                end
            end
            CMD_RD: begin
                if (auto_pre_i) begin
                    st_d.open[bank_i] = 1'b0;
                end
            end
            CMD_WR: begin
                if (auto_pre_i && st_q.open[bank_i] && !burst_on) begin
                    st_d.burst_cnt = CW'(HALF);
                    st_d.wbank     = bank_i;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = st_q.open;

endmodule

// File: rtl/ddr_mode_guard.sv
module ddr_mode_guard
    import ddr_mon_pkg::*;
#(
    parameter int MRS_GAP = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  cmd_e cmd_i,
    input  logic cke_i,
    input  logic any_open_i,
    output logic cke_prev_o,
    output logic sref_o,
    output logic pdn_o,
    output logic pdn_act_o,
    output logic viol_mode_o,
    output logic viol_refresh_o,
    output logic viol_gap_o
);

    localparam int GW = $clog2(MRS_GAP + 1);

    typedef struct packed {
        logic          cke;
        logic          sref;
        logic          pdn;
        logic          pdn_act;
        logic [GW-1:0] gap;
    } grd_t;

    grd_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cke = cke_i;

        viol_mode_o    = (cmd_i == CMD_MRS) && any_open_i;
        viol_refresh_o = ((cmd_i == CMD_AREF) || (cmd_i == CMD_SREF_IN)) && any_open_i;
        viol_gap_o     = (st_q.gap != '0) && !cmd_is_idle(cmd_i);

        if (cmd_i == CMD_MRS) begin
            st_d.gap = GW'(MRS_GAP);
        end else if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
        end

        unique case (cmd_i)
            CMD_SREF_IN:  st_d.sref = 1'b1;
            CMD_SREF_OUT: st_d.sref = 1'b0;
            CMD_PDN_IN: begin
                st_d.pdn     = 1'b1;
                st_d.pdn_act = any_open_i;
            end
            CMD_PDN_OUT: begin
                st_d.pdn     = 1'b0;
                st_d.pdn_act = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.cke <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cke_prev_o = st_q.cke;
    assign sref_o     = st_q.sref;
    assign pdn_o      = st_q.pdn;
    assign pdn_act_o  = st_q.pdn_act;

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int BURST_LEN = 4,
    parameter int TRP_CYC   = 3,
    parameter int MRS_GAP   = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cke_i,
    input  logic                 cs_ni,
    input  logic                 ras_ni,
    input  logic                 cas_ni,
    input  logic                 we_ni,
    input  logic [BA_W-1:0]      ba_i,
    input  logic                 a10_i,
    output logic [3:0]           cmd_o,
    output logic [BA_W-1:0]      bank_o,
    output logic                 all_banks_o,
    output logic                 auto_pre_o,
    output logic                 viol_state_o,
    output logic                 viol_mode_o,
    output logic                 viol_refresh_o,
    output logic                 viol_gap_o,
    output logic                 viol_wrap_o,
    output logic [(1<<BA_W)-1:0] bank_open_o,
    output logic                 sref_o,
    output logic                 pdn_o,
    output logic                 pdn_active_o
);

    localparam int NUM_BANKS = 1 << BA_W;

    typedef struct packed {
        logic [3:0]      cmd;
        logic [BA_W-1:0] bank;
        logic            all;
        logic            ap;
        logic            v_state;
        logic            v_mode;
        logic            v_ref;
        logic            v_gap;
        logic            v_wrap;
    } out_t;

    out_t out_d, out_q;

    cmd_e                 dec_cmd;
    logic [BA_W-1:0]      dec_bank;
    logic                 dec_all;
    logic                 dec_ap;
    logic                 cke_prev;
    logic                 in_sref;
    logic [NUM_BANKS-1:0] open_st;
    logic                 v_state, v_wrap, v_mode, v_ref, v_gap;

    ddr_cmd_decode #(.BA_W(BA_W)) dec_i (
        .cke_prev_i  (cke_prev),
        .cke_i       (cke_i),
        .in_sref_i   (in_sref),
        .cs_ni       (cs_ni),
        .ras_ni      (ras_ni),
        .cas_ni      (cas_ni),
        .we_ni       (we_ni),
        .ba_i        (ba_i),
        .a10_i       (a10_i),
        .cmd_o       (dec_cmd),
        .bank_o      (dec_bank),
        .all_banks_o (dec_all),
        .auto_pre_o  (dec_ap)
    );

    ddr_bank_track #(
        .BA_W      (BA_W),
        .BURST_LEN (BURST_LEN),
        .TRP_CYC   (TRP_CYC)
    ) trk_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cmd_i        (dec_cmd),
        .bank_i       (dec_bank),
        .all_banks_i  (dec_all),
        .auto_pre_i   (dec_ap),
        .open_o       (open_st),
        .viol_state_o (v_state),
        .viol_wrap_o  (v_wrap)
    );

    ddr_mode_guard #(.MRS_GAP(MRS_GAP)) grd_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .cmd_i          (dec_cmd),
        .cke_i          (cke_i),
        .any_open_i     (|open_st),
        .cke_prev_o     (cke_prev),
        .sref_o         (in_sref),
        .pdn_o          (pdn_o),
        .pdn_act_o      (pdn_active_o),
        .viol_mode_o    (v_mode),
        .viol_refresh_o (v_ref),
        .viol_gap_o     (v_gap)
    );

    always_comb begin
        out_d         = '0;
        out_d.cmd     = dec_cmd;
        out_d.bank    = dec_bank;
        out_d.all     = dec_all;
        out_d.ap      = dec_ap;
        out_d.v_state = v_state;
        out_d.v_mode  = v_mode;
        out_d.v_ref   = v_ref;
        out_d.v_gap   = v_gap;
        out_d.v_wrap  = v_wrap;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cmd_o          = out_q.cmd;
    assign bank_o         = out_q.bank;
    assign all_banks_o    = out_q.all;
    assign auto_pre_o     = out_q.ap;
    assign viol_state_o   = out_q.v_state;
    assign viol_mode_o    = out_q.v_mode;
    assign viol_refresh_o = out_q.v_ref;
    assign viol_gap_o     = out_q.v_gap;
    assign viol_wrap_o    = out_q.v_wrap;
    assign bank_open_o    = open_st;
    assign sref_o         = in_sref;

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk
    import ddr_mon_pkg::*;
#(
    parameter int BA_W = 2
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [3:0]           cmd_o,
    input logic [BA_W-1:0]      bank_o,
    input logic                 all_banks_o,
    input logic                 auto_pre_o,
    input logic                 viol_mode_o,
    input logic                 viol_refresh_o,
    input logic                 viol_gap_o,
    input logic [(1<<BA_W)-1:0] bank_open_o,
    input logic                 sref_o,
    input logic                 pdn_o
);

    assert_all_closes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        all_banks_o |-> (cmd_o == CMD_PRE) && (bank_open_o == '0));

    assert_ap_only_rw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        auto_pre_o |-> (cmd_o == CMD_RD) || (cmd_o == CMD_WR));

    assert_act_opens_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_ACT) |-> bank_open_o[bank_o]);

    assert_mode_viol_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_mode_o |-> (cmd_o == CMD_MRS));

    assert_gap_non_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_gap_o |-> (cmd_o != CMD_NOP) && (cmd_o != CMD_DESEL));

    assert_refresh_viol_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_refresh_o |-> (cmd_o == CMD_AREF) || (cmd_o == CMD_SREF_IN));

    assert_sref_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_SREF_OUT) |-> $past(sref_o) && !sref_o);

    assert_low_power_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sref_o && pdn_o));

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.BA_W(BA_W)) chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_o          (cmd_o),
    .bank_o         (bank_o),
    .all_banks_o    (all_banks_o),
    .auto_pre_o     (auto_pre_o),
    .viol_mode_o    (viol_mode_o),
    .viol_refresh_o (viol_refresh_o),
    .viol_gap_o     (viol_gap_o),
    .bank_open_o    (bank_open_o),
    .sref_o         (sref_o),
    .pdn_o          (pdn_o)
);

// File: tb/ddr_cmd_monitor_tb_top.sv
module ddr_cmd_monitor_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic [3:0] cmd;
    logic [1:0] bank;
    logic       all_b, ap, v_state, v_mode, v_ref, v_gap, v_wrap, sref, pdn, pdn_act;
    logic [3:0] open_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ddr_cmd_monitor dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
        .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .a10_i(a10), .cmd_o(cmd),
        .bank_o(bank), .all_banks_o(all_b), .auto_pre_o(ap), .viol_state_o(v_state),
        .viol_mode_o(v_mode), .viol_refresh_o(v_ref), .viol_gap_o(v_gap),
        .viol_wrap_o(v_wrap), .bank_open_o(open_b), .sref_o(sref), .pdn_o(pdn),
        .pdn_active_o(pdn_act)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one bus cycle at the falling edge, sample just after the rising edge
    task automatic bus(input logic k, input logic c, input logic r, input logic ca,
                       input logic w, input int b, input logic a);
        @(negedge clk);
        cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = 2'(b); a10 = a;
        @(posedge clk);
        #2;
    endtask

    task automatic nop();              bus(1, 0, 1, 1, 1, 0, 0); endtask
    task automatic act(input int b);   bus(1, 0, 0, 1, 1, b, 0); endtask
    task automatic rd(input int b, input logic a); bus(1, 0, 1, 0, 1, b, a); endtask
    task automatic wr(input int b, input logic a); bus(1, 0, 1, 0, 0, b, a); endtask
    task automatic pre(input int b, input logic a); bus(1, 0, 0, 1, 0, b, a); endtask
    task automatic mrs();              bus(1, 0, 0, 0, 0, 0, 0); endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int exp_code(input logic c, input logic r, input logic ca, input logic w);
        if (c) return 1;
        case ({r, ca, w})
            3'b000: return 2;
            3'b001: return 3;
            3'b010: return 9;
            3'b011: return 6;
            3'b100: return 8;
            3'b101: return 7;
            3'b110: return 10;
            default: return 0;
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R13: reset state
        repeat (2) @(posedge clk);
        #2;
        chk("R13 reset outputs", {cmd, bank, all_b, ap, v_state, v_mode, v_ref, v_gap, v_wrap,
                                  open_b, sref, pdn, pdn_act}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        bus(0, 0, 1, 1, 1, 0, 0);
        chk("R13 cke taken high after reset", cmd, 11);

        // R1 R2 R3 R4: sweep every pin pattern with clock enable held high
        do_reset();
        for (int i = 0; i < 128; i++) begin
            logic c, r, ca, w, a;
            int   b, code, eb, ea, eap;
            c = i[6]; r = i[5]; ca = i[4]; w = i[3]; a = i[2]; b = i & 3;
            bus(1, c, r, ca, w, b, a);
            code = exp_code(c, r, ca, w);
            eb   = (code == 6 || code == 7 || code == 8 || code == 9) ? b : 0;
            ea   = (code == 9) ? int'(a) : 0;
            eap  = (code == 7 || code == 8) ? int'(a) : 0;
            chk("R1/R2/R3/R4 decode", {cmd, bank, all_b, ap}, {code[3:0], eb[1:0], ea[0], eap[0]});
        end

        // R5: bank state per bank
        for (int b = 0; b < 4; b++) begin
            do_reset();
            rd(b, 0);
            chk("R5 read closed bank", v_state, 1);
            act(b);
            chk("R5 act idle bank", {v_state, open_b}, {1'b0, 4'(1 << b)});
            act(b);
            chk("R5 act open bank", v_state, 1);
            wr(b, 0);
            chk("R5 write open bank", v_state, 0);
            pre(b, 0);
            chk("R3 single precharge", open_b, 0);
        end

        // R3: precharge all ignores BA, single closes only its bank
        do_reset();
        act(0); act(2); act(3);
        pre(2, 0);
        chk("R3 single precharge keeps others", open_b, 4'b1001);
        pre(1, 1);
        chk("R3 precharge all", {all_b, open_b}, {1'b1, 4'b0000});

        // R4: read with auto-precharge closes bank
        act(1);
        rd(1, 1);
        chk("R4 read auto-precharge", {ap, open_b}, {1'b1, 4'b0000});

        // R6 R7: mode write rules
        do_reset();
        mrs();
        chk("R6 mode write idle", {v_mode, v_gap}, 0);
        nop();
        chk("R7 nop in gap", v_gap, 0);
        act(0);
        chk("R7 act in gap", v_gap, 1);
        pre(1, 0);
        chk("R7 after gap", v_gap, 0);
        mrs();
        chk("R6 mode write with open bank", v_mode, 1);

        // R8: refresh with open bank
        do_reset();
        act(3);
        bus(1, 0, 0, 0, 1, 0, 0);
        chk("R8 refresh with open bank", {cmd, 3'b000, v_ref}, {4'd3, 3'b000, 1'b1});
        pre(0, 1);
        bus(1, 0, 0, 0, 1, 0, 0);
        chk("R8 refresh idle", v_ref, 0);

        // R9: self-refresh
        do_reset();
        bus(0, 0, 0, 0, 1, 0, 0);
        chk("R9 sref entry", {cmd, sref, v_ref}, {4'd4, 1'b1, 1'b0});
        bus(0, 1, 1, 1, 1, 0, 0);
        chk("R10 cke low both edges", {cmd, sref}, {4'd0, 1'b1});
        bus(1, 1, 1, 1, 1, 0, 0);
        chk("R9 sref exit", {cmd, sref, pdn}, {4'd5, 1'b0, 1'b0});
        act(0);
        bus(0, 0, 0, 0, 1, 0, 0);
        chk("R8 sref entry with open bank", {cmd, v_ref}, {4'd4, 1'b1});
        bus(1, 1, 1, 1, 1, 0, 0);

        // R10: power-down
        do_reset();
        act(3);
        bus(0, 0, 1, 1, 1, 0, 0);
        chk("R10 active pdn entry", {cmd, pdn, pdn_act, sref}, {4'd11, 1'b1, 1'b1, 1'b0});
        bus(0, 1, 1, 1, 1, 0, 0);
        chk("R10 pdn hold", {cmd, pdn}, {4'd0, 1'b1});
        bus(1, 0, 1, 1, 1, 0, 0);
        chk("R10 pdn exit", {cmd, pdn, pdn_act}, {4'd12, 1'b0, 1'b0});
        pre(0, 1);
        bus(0, 1, 1, 1, 1, 0, 0);
        chk("R10 precharge pdn entry", {cmd, pdn, pdn_act}, {4'd11, 1'b1, 1'b0});
        bus(1, 1, 1, 1, 1, 0, 0);

        // R11 R12: write with auto-precharge, burst of 2 edges, tRP of 3 edges
        do_reset();
        act(0); act(1);
        wr(0, 1);
        chk("R11 write-ap issue", {v_wrap, v_state}, 0);
        rd(1, 0);
        chk("R11 read during burst", v_wrap, 1);
        nop();
        chk("R11 bank closes at burst end", open_b, 4'b0010);
        rd(1, 0);
        chk("R11 other bank after burst", {v_wrap, v_state}, 0);
        act(2);
        chk("R12 act other bank in tRP", {v_wrap, v_state}, 0);
        act(0);
        chk("R12 act same bank in tRP", v_wrap, 1);

        do_reset();
        act(0); act(1);
        wr(0, 1);
        repeat (5) nop();
        act(0);
        chk("R12 act after tRP", {v_wrap, v_state}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule